// File: doc/BRIEF.md
# Per-Channel Multi-Source Trigger Generator

This block gives each DSP channel its own one-cycle trigger strobe. Every signal it uses is in the DSP clock domain. Each channel has two configuration fields. A type field selects which event stream can fire the channel. A select field picks one bit of the software trigger vector or one bit of the external trigger pin vector. The software bit acts as an edge source or as a level gate, depending on the type.

Shared front logic finds the rising edges of the software bits, the pins, the SYSREF strobe and the fast-reconfiguration chip select. The chip select is active low, so its rising edge marks the end of a transaction. One shared detector watches the least significant bit of data stream 0 for a run of four lows followed by four highs.

Per-channel logic holds two pieces of state. One is an armed flag for the SYSREF one-shot type. The other is a pending flag for the type that waits for the trigger clock after a chip-select edge. The configuration registers reset to zero. With that configuration, every channel uses type 0 on software bit 0, so a 0-to-1 change of that bit fires all channels in the same cycle.

Top module: `trig_gen_top`

## Requirements
- R1: While reset is low, and in the first cycle after it is released with all other inputs idle, `trig_o` is all zeros.
- R2: Type 0 (type field value 0): a channel pulses `trig_o` in the cycle after a 0-to-1 change of the software bit it selects. All channels that select the same bit pulse in the same cycle. With every field at zero, a rise of bit 0 fires all channels.
- R3: Type 1: a software-bit rise arms the channel. The next SYSREF rise, taken while `clk_aligned_i` is high, fires the channel once and disarms it. A later SYSREF rise does not fire it again until it is re-armed.
- R4: Type 2: every SYSREF rise fires the channel while its selected software bit is high. No SYSREF rise fires it while that bit is low.
- R5: In types 1 and 2, a SYSREF rise taken while `clk_aligned_i` is low does not fire the channel. In type 1 such a rise leaves the channel armed.
- R6: Type 3: while the selected software bit is high, the channel fires in the cycle after the fourth consecutive high sample of `stream0_lsb_i`, provided those highs directly follow at least four consecutive low samples. While the bit is low, the channel never fires.
- R7: Type 3 restart rules. A run of fewer than four lows does not qualify. A low sample inside the high run restarts the low count at one. After a firing, a fresh run of four lows is required before the next firing.
- R8: Type 4: the channel fires in the cycle after a 0-to-1 change of the external pin it selects. Edges on other pins do not fire it.
- R9: Type 5: while `fr_en_i` is high, the channel fires in the cycle after a 0-to-1 change of `fr_cs_n_i`. While `fr_en_i` is low, such a change does nothing.
- R10: Type 6: while `fr_en_i` is high, the channel fires in the cycle after the first `trig_clk_tick_i` strobe that comes strictly after a chip-select rise. A strobe in the same cycle as the rise does not count.
- R11: Type 7 is unused, and a channel set to it never fires.
- R12: Every firing lasts exactly one cycle. Holding a source high does not fire the channel again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DSP clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_type_i | input | NCH*3 | Type field of channel i at bits [3i+2:3i] |
| chan_sel_i | input | NCH*SELW | Source index of channel i at bits [SELW*i +: SELW] |
| sw_trig_i | input | NSW | Software trigger bits, already synchronized |
| sysref_i | input | 1 | SYSREF strobe |
| clk_aligned_i | input | 1 | High when SYSREF timing agrees with the internal clocks |
| stream0_lsb_i | input | 1 | Least significant bit of data stream 0, one sample per cycle |
| ext_trig_i | input | NPIN | External trigger pins, already synchronized |
| trig_clk_tick_i | input | 1 | One-cycle marker of a trigger-clock rising edge |
| fr_cs_n_i | input | 1 | Fast-reconfiguration chip select, active low |
| fr_en_i | input | 1 | Fast-reconfiguration trigger enable |
| trig_o | output | NCH | One-cycle trigger strobe per channel |

## Verification
A stuck or stale armed flag in type 1 shows up at the very next SYSREF rise. The port then shows either a missing strobe or a second strobe with no new arming. A stuck pending flag in type 6 shows up the same way at the next trigger-clock tick. A wrong count in the pattern detector shows up within eight samples as an early, late or missing strobe, so the bench feeds runs that are short, broken, exact and over-long. A fault in edge detection shows as a repeated strobe while a source is held high, which the checks on the cycles after each edge catch.

// File: rtl/trig_gen_pkg.sv
package trig_gen_pkg;

    typedef enum logic [2:0] {
        TT_SW_NOW    = 3'd0,
        TT_SREF_ONCE = 3'd1,
        TT_SREF_CONT = 3'd2,
        TT_LSB_PAT   = 3'd3,
        TT_PIN       = 3'd4,
        TT_FR_NOW    = 3'd5,
        TT_FR_TCLK   = 3'd6,
        TT_OFF       = 3'd7
    } trig_type_e;

    localparam int TYPE_W = 3;

endpackage

// File: rtl/trig_edge_front.sv
module trig_edge_front #(
    parameter int NSW  = 4,
    parameter int NPIN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSW-1:0]  sw_i,
    input  logic [NPIN-1:0] pin_i,
    input  logic            sysref_i,
    input  logic            cs_n_i,
    output logic [NSW-1:0]  sw_rise_o,
    output logic [NPIN-1:0] pin_rise_o,
    output logic            sysref_rise_o,
    output logic            cs_rise_o
);

    typedef struct packed {
        logic [NSW-1:0]  sw;
        logic [NPIN-1:0] pin;
        logic            sysref;
        logic            cs_n;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d        = prev_q;
        prev_d.sw     = sw_i;
        prev_d.pin    = pin_i;
        prev_d.sysref = sysref_i;
        prev_d.cs_n   = cs_n_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q.sw     <= '0;
            prev_q.pin    <= '0;
            prev_q.sysref <= 1'b0;
            prev_q.cs_n   <= 1'b1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign sw_rise_o     = sw_i & ~prev_q.sw;
    assign pin_rise_o    = pin_i & ~prev_q.pin;
    assign sysref_rise_o = sysref_i & ~prev_q.sysref;
    assign cs_rise_o     = cs_n_i & ~prev_q.cs_n;

    AST_SREF_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sysref_rise_o |=> !sysref_rise_o) else $error("sysref rise repeated"); // R12

endmodule

// File: rtl/trig_lsb_pattern.sv
module trig_lsb_pattern #(
    parameter int RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lsb_i,
    output logic hit_o
);

    localparam int CW = $clog2(RUN + 1);

    typedef struct packed {
        logic          in_high;
        logic [CW-1:0] cnt;
    } pat_t;

    pat_t pat_d, pat_q;

    always_comb begin
        pat_d = pat_q;
        hit_o = 1'b0;
        if (!pat_q.in_high) begin
            if (!lsb_i) begin
                if (pat_q.cnt != CW'(RUN)) pat_d.cnt = pat_q.cnt + 1'b1;
            end else if (pat_q.cnt == CW'(RUN)) begin
                pat_d.in_high = 1'b1;
                pat_d.cnt     = CW'(1);
            end else begin
                pat_d.cnt = '0;
            end
        end else begin
            if (lsb_i) begin
                if (pat_q.cnt == CW'(RUN - 1)) begin
                    hit_o         = 1'b1;
                    pat_d.in_high = 1'b0;
                    pat_d.cnt     = '0;
                end else begin
                    pat_d.cnt = pat_q.cnt + 1'b1;
                end
            end else begin
                pat_d.in_high = 1'b0;
                pat_d.cnt     = CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pat_q <= '0;
        else        pat_q <= pat_d;
    end

    AST_PAT_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pat_q.cnt <= CW'(RUN)) else $error("pattern count overrun"); // R6

    AST_PAT_HIT_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (!pat_q.in_high && pat_q.cnt == '0)) else $error("no fresh run after hit"); // R7

endmodule

// File: rtl/trig_channel.sv
module trig_channel
    import trig_gen_pkg::*;
#(
    parameter int NSW  = 4,
    parameter int NPIN = 4,
    parameter int SELW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TYPE_W-1:0] type_i,
    input  logic [SELW-1:0]   sel_i,
    input  logic [NSW-1:0]    sw_lvl_i,
    input  logic [NSW-1:0]    sw_rise_i,
    input  logic [NPIN-1:0]   pin_rise_i,
    input  logic              sysref_rise_i,
    input  logic              aligned_i,
    input  logic              pat_hit_i,
    input  logic              cs_rise_i,
    input  logic              tclk_i,
    input  logic              fr_en_i,
    output logic              fire_o
);

    typedef struct packed {
        logic armed;
        logic pend;
        logic fire;
    } ch_t;

    ch_t ch_d, ch_q;

    logic sw_lvl, sw_rise, pin_rise;
    logic fire_now;

    always_comb begin
        sw_lvl   = 1'b0;
        sw_rise  = 1'b0;
        pin_rise = 1'b0;
        for (int i = 0; i < NSW; i++) begin
            if (sel_i == SELW'(i)) begin
                sw_lvl  = sw_lvl_i[i];
                sw_rise = sw_rise_i[i];
            end
        end
        for (int i = 0; i < NPIN; i++) begin
            if (sel_i == SELW'(i)) pin_rise = pin_rise_i[i];
        end
    end

    always_comb begin
        ch_d     = ch_q;
        fire_now = 1'b0;
        if (trig_type_e'(type_i) != TT_SREF_ONCE) ch_d.armed = 1'b0;
        if (trig_type_e'(type_i) != TT_FR_TCLK || !fr_en_i) ch_d.pend = 1'b0;
        case (trig_type_e'(type_i))
            TT_SW_NOW:    fire_now = sw_rise;
            TT_SREF_ONCE: begin
                fire_now   = ch_q.armed && sysref_rise_i && aligned_i;
                ch_d.armed = (ch_q.armed && !fire_now) || sw_rise;
            end
            TT_SREF_CONT: fire_now = sw_lvl && sysref_rise_i && aligned_i;
            TT_LSB_PAT:   fire_now = sw_lvl && pat_hit_i;
            TT_PIN:       fire_now = pin_rise;
            TT_FR_NOW:    fire_now = fr_en_i && cs_rise_i;
            TT_FR_TCLK: begin
                if (fr_en_i) begin
                    fire_now  = ch_q.pend && tclk_i;
                    ch_d.pend = (ch_q.pend && !fire_now) || cs_rise_i;
                end
            end
            default:      fire_now = 1'b0;
        endcase
        ch_d.fire = fire_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign fire_o = ch_q.fire;

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (type_i == 3'd7) |=> !fire_o) else $error("type 7 fired"); // R11

    AST_SREF_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ((type_i == 3'd1 || type_i == 3'd2) && !aligned_i) |=> !fire_o)
        else $error("SYSREF fired while misaligned"); // R5

    AST_ONCE_ARMED_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (type_i == 3'd1 && ch_q.armed && sysref_rise_i && aligned_i) |=> fire_o)
        else $error("armed channel missed SYSREF"); // R3

    AST_TCLK_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (type_i == 3'd6 && fr_en_i && ch_q.pend && tclk_i) |=> fire_o)
        else $error("pending channel missed trigger clock"); // R10

endmodule

// File: rtl/trig_gen_top.sv
module trig_gen_top
    import trig_gen_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int NSW     = 4,
    parameter int NPIN    = 4,
    parameter int PAT_RUN = 4,
    localparam int SPAN   = (NSW > NPIN) ? NSW : NPIN,
    localparam int SELW   = (SPAN > 1) ? $clog2(SPAN) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH*TYPE_W-1:0]  chan_type_i,
    input  logic [NCH*SELW-1:0]    chan_sel_i,
    input  logic [NSW-1:0]         sw_trig_i,
    input  logic                   sysref_i,
    input  logic                   clk_aligned_i,
    input  logic                   stream0_lsb_i,
    input  logic [NPIN-1:0]        ext_trig_i,
    input  logic                   trig_clk_tick_i,
    input  logic                   fr_cs_n_i,
    input  logic                   fr_en_i,
    output logic [NCH-1:0]         trig_o
);

    logic [NSW-1:0]  sw_rise;
    logic [NPIN-1:0] pin_rise;
    logic            sysref_rise;
    logic            cs_rise;
    logic            pat_hit;

    trig_edge_front #(.NSW(NSW), .NPIN(NPIN)) u_front (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_i          (sw_trig_i),
        .pin_i         (ext_trig_i),
        .sysref_i      (sysref_i),
        .cs_n_i        (fr_cs_n_i),
        .sw_rise_o     (sw_rise),
        .pin_rise_o    (pin_rise),
        .sysref_rise_o (sysref_rise),
        .cs_rise_o     (cs_rise)
    );

    trig_lsb_pattern #(.RUN(PAT_RUN)) u_pat (
        .clk   (clk),
        .rst_n (rst_n),
        .lsb_i (stream0_lsb_i),
        .hit_o (pat_hit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        trig_channel #(.NSW(NSW), .NPIN(NPIN), .SELW(SELW)) u_ch (
            .clk           (clk),
            .rst_n         (rst_n),
            .type_i        (chan_type_i[c*TYPE_W +: TYPE_W]),
            .sel_i         (chan_sel_i[c*SELW +: SELW]),
            .sw_lvl_i      (sw_trig_i),
            .sw_rise_i     (sw_rise),
            .pin_rise_i    (pin_rise),
            .sysref_rise_i (sysref_rise),
            .aligned_i     (clk_aligned_i),
            .pat_hit_i     (pat_hit),
            .cs_rise_i     (cs_rise),
            .tclk_i        (trig_clk_tick_i),
            .fr_en_i       (fr_en_i),
            .fire_o        (trig_o[c])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> trig_o == '0) else $error("strobe out of reset"); // R1

endmodule

// File: tb/trig_gen_top_tb_top.sv
module trig_gen_top_tb_top;

    localparam int NCH = 4;
    localparam int NSW = 4;
    localparam int NPIN = 4;
    localparam int SELW = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                rst_n;
    logic [NCH*3-1:0]    typ;
    logic [NCH*SELW-1:0] sel;
    logic [NSW-1:0]      sw;
    logic                sysref, aligned, lsb, tclk, cs_n, fr_en;
    logic [NPIN-1:0]     pin;
    logic [NCH-1:0]      trig_o;

    trig_gen_top dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .chan_type_i     (typ),
        .chan_sel_i      (sel),
        .sw_trig_i       (sw),
        .sysref_i        (sysref),
        .clk_aligned_i   (aligned),
        .stream0_lsb_i   (lsb),
        .ext_trig_i      (pin),
        .trig_clk_tick_i (tclk),
        .fr_cs_n_i       (cs_n),
        .fr_en_i         (fr_en),
        .trig_o          (trig_o)
    );

    typedef struct {
        logic [NCH-1:0] v;
        string          r;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;

    // monitor: compares one expected item per clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            checks++;
            if (trig_o !== it.v) begin
                fails++;
                $display("FAIL %s: trig_o=%b expected %b at %0t", it.r, trig_o, it.v, $time);
            end
        end
    end

    // driver: inputs already applied at this negedge; queue the expectation
    task automatic cyc(input logic [NCH-1:0] e, input string r);
        exp_t it;
        it.v = e;
        it.r = r;
        exp_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic only(input int ch, input logic [2:0] t, input logic [SELW-1:0] s);
        typ = {NCH{3'd7}};
        sel = '0;
        typ[ch*3 +: 3] = t;
        sel[ch*SELW +: SELW] = s;
    endtask

    task automatic lsb_run(input logic v, input int n, input logic [NCH-1:0] last, input string r);
        for (int i = 0; i < n; i++) begin
            lsb = v;
            cyc((i == n - 1) ? last : '0, r);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; typ = '0; sel = '0; sw = '0; sysref = 0; aligned = 1;
        lsb = 0; tclk = 0; cs_n = 1; fr_en = 0; pin = '0;
        repeat (3) @(negedge clk);
        if (trig_o !== '0) begin
            fails++;
            $display("FAIL R1: trig_o=%b expected 0000 in reset", trig_o);
        end
        checks++;
        rst_n = 1'b1;
        cyc(4'b0000, "R1");
        cyc(4'b0000, "R1");

        // R2: default config, bit 0 fires all
        sw = 4'b0001; cyc(4'b1111, "R2");
        cyc(4'b0000, "R12 held");
        sw = 4'b0000; cyc(4'b0000, "R2 fall");
        // R2: binding
        sel = {2'd2, 2'd1, 2'd1, 2'd0};
        sw = 4'b0010; cyc(4'b0110, "R2 shared bit");
        cyc(4'b0000, "R12");
        sw = 4'b0110; cyc(4'b1000, "R2 bit2");
        sw = 4'b0000; cyc(4'b0000, "R2");

        // R3 / R5: one-shot on ch0
        only(0, 3'd1, 2'd0);
        sysref = 1; cyc(4'b0000, "R3 unarmed");
        sysref = 0; cyc(4'b0000, "R3");
        sw = 4'b0001; cyc(4'b0000, "R3 arm");
        sysref = 1; cyc(4'b0001, "R3 fire");
        sysref = 0; cyc(4'b0000, "R12");
        sysref = 1; cyc(4'b0000, "R3 disarmed");
        sysref = 0; sw = 4'b0000; cyc(4'b0000, "R3");
        sw = 4'b0001; cyc(4'b0000, "R3 rearm");
        aligned = 0; sysref = 1; cyc(4'b0000, "R5 misaligned");
        sysref = 0; aligned = 1; cyc(4'b0000, "R5");
        sysref = 1; cyc(4'b0001, "R5 still armed");
        sysref = 0; sw = 4'b0000; cyc(4'b0000, "R3");

        // R4 / R5: continuous on ch1, bit 1
        only(1, 3'd2, 2'd1);
        sw = 4'b0010; cyc(4'b0000, "R4 level");
        sysref = 1; cyc(4'b0010, "R4 first");
        sysref = 0; cyc(4'b0000, "R4");
        sysref = 1; cyc(4'b0010, "R4 second");
        sysref = 0; cyc(4'b0000, "R4");
        aligned = 0; sysref = 1; cyc(4'b0000, "R5 cont misaligned");
        sysref = 0; aligned = 1; sw = 4'b0000; cyc(4'b0000, "R4");
        sysref = 1; cyc(4'b0000, "R4 gate low");
        sysref = 0; cyc(4'b0000, "R4");

        // R6 / R7: pattern on ch2, bit 3
        only(2, 3'd3, 2'd3);
        lsb_run(1'b1, 5, 4'b0000, "R6 gate low");
        sw = 4'b1000;
        lsb_run(1'b0, 4, 4'b0000, "R6 lows");
        lsb_run(1'b1, 4, 4'b0100, "R6 fire");
        lsb_run(1'b1, 1, 4'b0000, "R7 after fire");
        lsb_run(1'b0, 3, 4'b0000, "R7 short lows");
        lsb_run(1'b1, 4, 4'b0000, "R7 short run");
        lsb_run(1'b0, 4, 4'b0000, "R7 lows");
        lsb_run(1'b1, 2, 4'b0000, "R7 highs");
        lsb_run(1'b0, 1, 4'b0000, "R7 break");
        lsb_run(1'b1, 4, 4'b0000, "R7 broken run");
        lsb_run(1'b0, 6, 4'b0000, "R6 long lows");
        lsb_run(1'b1, 4, 4'b0100, "R6 fire again");
        lsb = 0; sw = 4'b0000; cyc(4'b0000, "R6");

        // R8: pin on ch3, pin 2
        only(3, 3'd4, 2'd2);
        pin = 4'b0010; cyc(4'b0000, "R8 other pin");
        pin = 4'b0110; cyc(4'b1000, "R8 fire");
        cyc(4'b0000, "R12 pin held");
        pin = 4'b0000; cyc(4'b0000, "R8");

        // R9: fast-reconfig immediate on ch0
        only(0, 3'd5, 2'd0);
        fr_en = 1; cs_n = 0; cyc(4'b0000, "R9 cs low");
        cs_n = 1; cyc(4'b0001, "R9 fire");
        cs_n = 0; fr_en = 0; cyc(4'b0000, "R9");
        cs_n = 1; cyc(4'b0000, "R9 disabled");

        // R10: cs then trigger clock on ch1
        only(1, 3'd6, 2'd0);
        fr_en = 1; cs_n = 0; cyc(4'b0000, "R10");
        cs_n = 1; cyc(4'b0000, "R10 pend");
        tclk = 1; cyc(4'b0010, "R10 fire");
        tclk = 0; cyc(4'b0000, "R10");
        tclk = 1; cyc(4'b0000, "R10 consumed");
        tclk = 0; cs_n = 0; cyc(4'b0000, "R10");
        cs_n = 1; tclk = 1; cyc(4'b0000, "R10 same cycle");
        tclk = 0; cyc(4'b0000, "R10");
        tclk = 1; cyc(4'b0010, "R10 next tick");
        tclk = 0; fr_en = 0; cyc(4'b0000, "R10");

        // R11: all channels off
        typ = {NCH{3'd7}}; sel = '0;
        sw = 4'b1111; pin = 4'b1111; sysref = 1; cyc(4'b0000, "R11");
        sw = '0; pin = '0; sysref = 0; cyc(4'b0000, "R11");

        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule